// File: doc/BRIEF.md
# Hidden-Pointer OR-Addressing Load/Store Address Unit

This block forms memory addresses for a core that runs four hardware threads. Each thread has sixteen architectural registers, and only the top four of them (numbers 12 to 15) can hold a pointer. A pointer becomes usable through a separate validate operation. That operation sends the virtual address to a translation lookup port and stores the returned physical address in a hidden slot. The slot is tied to that thread and that pointer register, and it carries a valid bit. A translation fault is reported at this validate step and never later.

Loads and stores never carry a virtual address. They name a thread, a pointer register number and a 12-bit offset. The offset comes either from an immediate or from the low bits of a register operand. The unit ORs the offset into the hidden physical address, so no adder is needed, and it forces the two lowest address bits to zero. The result is one aligned 32-bit memory request, issued one cycle after the operation. A store also forwards its data operand. An access through a register outside the pointer window, or through a slot that is not valid, raises an error flag instead of a request.

Hidden slots are part of thread state. A global flush clears every slot in one cycle. A per-thread invalidate clears the four slots of one thread.

Top module: `hpor_lsu`

## Requirements
- R1: After reset, mem_req, op_err, val_done and val_fault are 0, and every hidden slot is invalid, so any load or store gives op_err.
- R2: Every cycle with op_req=1 is followed one cycle later by exactly one of mem_req or op_err. A cycle with op_req=0 is followed by neither.
- R3: A validate naming register 12..15 drives tlb_req=1 and tlb_va=val_vaddr in the same cycle. With tlb_fault=0, it stores tlb_pa as that slot's physical address and marks the slot valid. One cycle later val_done=1 and val_fault=0.
- R4: A validate answered with tlb_fault=1 reports val_fault=1 and leaves the slot invalid, even if the slot was valid before.
- R5: A validate naming register 0..11 keeps tlb_req=0, reports val_done=1 with val_fault=1, and changes no slot.
- R6: A load or store naming register 0..11 gives op_err=1 and no mem_req.
- R7: A load or store through an invalid slot gives op_err=1 and no mem_req.
- R8: The request address is the hidden physical address ORed with the zero-extended 12-bit offset, with bits 1:0 forced to 0.
- R9: With op_use_imm=1 the offset is op_imm. With op_use_imm=0 it is op_roff[11:0], and op_roff[31:12] has no effect.
- R10: For a store (op_store=1) the request has mem_we=1 and mem_wdata=op_wdata. For a load it has mem_we=0 and mem_wdata=0.
- R11: flush_all clears every slot of every thread in one cycle. A validate in the same cycle reports val_fault=1 and leaves its slot invalid.
- R12: inv_thr_req clears only the four slots of thread inv_thr_id. A validate to that thread in the same cycle reports val_fault=1 and is dropped. A validate to another thread proceeds.
- R13: Each (thread, pointer register) pair has its own slot. Writing one slot leaves the other fifteen unchanged.
- R14: A load or store issued in the same cycle as a validate, flush or invalidate sees the slot state from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate every hidden slot |
| inv_thr_req | input | 1 | Invalidate one thread's slots |
| inv_thr_id | input | 2 | Thread to invalidate |
| val_req | input | 1 | Validate operation request |
| val_tid | input | 2 | Thread of the validate |
| val_preg | input | 4 | Register number being validated |
| val_vaddr | input | 32 | Virtual address to translate |
| tlb_req | output | 1 | Translation lookup request |
| tlb_va | output | 32 | Virtual address for lookup |
| tlb_pa | input | 32 | Translated physical address (same cycle) |
| tlb_fault | input | 1 | Translation fault (same cycle) |
| val_done | output | 1 | Validate response strobe |
| val_fault | output | 1 | Validate rejected |
| op_req | input | 1 | Load/store request |
| op_tid | input | 2 | Thread of the access |
| op_preg | input | 4 | Pointer register number |
| op_store | input | 1 | 1 = store, 0 = load |
| op_use_imm | input | 1 | Offset source select |
| op_imm | input | 12 | Immediate offset |
| op_roff | input | 32 | Register offset operand |
| op_wdata | input | 32 | Store data operand |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Aligned physical address |
| mem_wdata | output | 32 | Write data |
| op_err | output | 1 | Access rejected |

## Verification
The hardest cases are collisions inside one cycle. These are an access meeting a validate or a flush of its own slot, and a thread invalidate meeting a validate. They occur only when several independent inputs line up on the same edge. The bench therefore drives every input in every cycle, and a reference model of all sixteen slots predicts each response from the state before the edge. Directed cycles then place an access together with a re-validate of the same slot, and an access together with a flush. They also place an invalidate of one thread together with a validate to the same thread and to another thread. Full sweeps over all threads and registers follow to show which slots survived.

// File: rtl/hpor_pkg.sv
package hpor_pkg;

    // Result of checking the pointer named by a load or store
    typedef enum logic [1:0] {
        CHK_OK      = 2'd0,
        CHK_NOT_PTR = 2'd1,
        CHK_STALE   = 2'd2
    } ptr_chk_e;

    // Direction of a memory access
    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_e;

endpackage

// File: rtl/hpor_ptr_file.sv
module hpor_ptr_file #(
    parameter int THREADS = 4,
    parameter int NPTR    = 4,
    parameter int AW      = 32,
    localparam int TIDW   = $clog2(THREADS),
    localparam int PIW    = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_all,
    input  logic            inv_req,
    input  logic [TIDW-1:0] inv_tid,
    input  logic            wr_en,
    input  logic [TIDW-1:0] wr_tid,
    input  logic [PIW-1:0]  wr_pidx,
    input  logic            wr_ok,
    input  logic [AW-1:0]   wr_pa,
    input  logic [TIDW-1:0] rd_tid,
    input  logic [PIW-1:0]  rd_pidx,
    output logic [AW-1:0]   rd_pa,
    output logic            rd_valid
);

    localparam int NENT = THREADS * NPTR;
    localparam int EW   = $clog2(NENT);

    typedef struct packed {
        logic [NENT-1:0]         vld;
        logic [NENT-1:0][AW-1:0] pa;
    } slots_t;

    slots_t          st_d, st_q;
    logic [NENT-1:0] thr_mask;
    logic [EW-1:0]   widx;
    logic [EW-1:0]   ridx;

    // One mask bit per slot: set when its owning thread is being invalidated
    generate
        for (genvar e = 0; e < NENT; e++) begin : g_thr_mask
            assign thr_mask[e] = inv_req && (inv_tid == TIDW'(e / NPTR));
        end
    endgenerate

    assign widx = EW'(wr_tid) * EW'(NPTR) + EW'(wr_pidx);
    assign ridx = EW'(rd_tid) * EW'(NPTR) + EW'(rd_pidx);

    always_comb begin
        st_d = st_q;
        if (flush_all) begin
            st_d.vld = '0;
        end else begin
            if (wr_en) begin
                st_d.vld[widx] = wr_ok;
                if (wr_ok) begin
                    st_d.pa[widx] = wr_pa;
                end
            end
            // thread invalidate overrides a write landing in the same thread
            st_d.vld = st_d.vld & ~thr_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.vld[ridx];
    assign rd_pa    = st_q.pa[ridx];

endmodule

// File: rtl/hpor_val_stage.sv
module hpor_val_stage #(
    parameter int THREADS = 4,
    parameter int NREG    = 16,
    parameter int NPTR    = 4,
    parameter int AW      = 32,
    localparam int TIDW   = $clog2(THREADS),
    localparam int RIDW   = $clog2(NREG),
    localparam int PIW    = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_all,
    input  logic            inv_req,
    input  logic [TIDW-1:0] inv_tid,
    input  logic            val_req,
    input  logic [TIDW-1:0] val_tid,
    input  logic [RIDW-1:0] val_preg,
    input  logic [AW-1:0]   val_vaddr,
    output logic            tlb_req,
    output logic [AW-1:0]   tlb_va,
    input  logic [AW-1:0]   tlb_pa,
    input  logic            tlb_fault,
    output logic            wr_en,
    output logic [TIDW-1:0] wr_tid,
    output logic [PIW-1:0]  wr_pidx,
    output logic            wr_ok,
    output logic [AW-1:0]   wr_pa,
    output logic            val_done,
    output logic            val_fault
);

    localparam int PTR_BASE = NREG - NPTR;

    typedef struct packed {
        logic done;
        logic fault;
    } vrsp_t;

    vrsp_t rsp_d, rsp_q;
    logic  is_ptr;
    logic  blocked;

    always_comb begin
        is_ptr  = (val_preg >= RIDW'(PTR_BASE));
        blocked = flush_all || (inv_req && (inv_tid == val_tid));

        tlb_req = val_req && is_ptr;
        tlb_va  = val_vaddr;

        wr_en   = tlb_req && !blocked;
        wr_tid  = val_tid;
        wr_pidx = PIW'(val_preg - RIDW'(PTR_BASE));
        wr_ok   = !tlb_fault;
        wr_pa   = tlb_pa;

        rsp_d.done  = val_req;
        rsp_d.fault = val_req && (!is_ptr || blocked || tlb_fault);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign val_done  = rsp_q.done;
    assign val_fault = rsp_q.fault;

endmodule

// File: rtl/hpor_ea_form.sv
module hpor_ea_form
    import hpor_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int NPTR  = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int OFFW  = 12,
    localparam int RIDW = $clog2(NREG),
    localparam int PIW  = $clog2(NPTR)
) (
    input  logic [RIDW-1:0] op_preg,
    input  logic            ptr_valid,
    input  logic [AW-1:0]   ptr_pa,
    input  logic            use_imm,
    input  logic [OFFW-1:0] imm,
    input  logic [DW-1:0]   roff,
    output ptr_chk_e        chk,
    output logic [PIW-1:0]  pidx,
    output logic [AW-1:0]   ea
);

    localparam int PTR_BASE = NREG - NPTR;
    localparam int ALIGN    = $clog2(DW / 8);
    localparam logic [AW-1:0] LOW_MASK = AW'((1 << ALIGN) - 1);

    logic            is_ptr;
    logic [OFFW-1:0] off;
    logic            unused_roff_hi;

    assign unused_roff_hi = ^roff[DW-1:OFFW];

    always_comb begin
        is_ptr = (op_preg >= RIDW'(PTR_BASE));
        pidx   = PIW'(op_preg - RIDW'(PTR_BASE));
        off    = use_imm ? imm : roff[OFFW-1:0];
        ea     = (ptr_pa | AW'(off)) & ~LOW_MASK;
        if (!is_ptr) begin
            chk = CHK_NOT_PTR;
        end else if (!ptr_valid) begin
            chk = CHK_STALE;
        end else begin
            chk = CHK_OK;
        end
    end

endmodule

// File: rtl/hpor_lsu.sv
module hpor_lsu
    import hpor_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int NREG    = 16,
    parameter int NPTR    = 4,
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int OFFW    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_all,
    input  logic                       inv_thr_req,
    input  logic [$clog2(THREADS)-1:0] inv_thr_id,
    input  logic                       val_req,
    input  logic [$clog2(THREADS)-1:0] val_tid,
    input  logic [$clog2(NREG)-1:0]    val_preg,
    input  logic [AW-1:0]              val_vaddr,
    output logic                       tlb_req,
    output logic [AW-1:0]              tlb_va,
    input  logic [AW-1:0]              tlb_pa,
    input  logic                       tlb_fault,
    output logic                       val_done,
    output logic                       val_fault,
    input  logic                       op_req,
    input  logic [$clog2(THREADS)-1:0] op_tid,
    input  logic [$clog2(NREG)-1:0]    op_preg,
    input  logic                       op_store,
    input  logic                       op_use_imm,
    input  logic [OFFW-1:0]            op_imm,
    input  logic [DW-1:0]              op_roff,
    input  logic [DW-1:0]              op_wdata,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [DW-1:0]              mem_wdata,
    output logic                       op_err
);

    localparam int TIDW = $clog2(THREADS);
    localparam int PIW  = $clog2(NPTR);

    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          err;
    } mout_t;

    logic            wr_en;
    logic [TIDW-1:0] wr_tid;
    logic [PIW-1:0]  wr_pidx;
    logic            wr_ok;
    logic [AW-1:0]   wr_pa;
    logic [PIW-1:0]  rd_pidx;
    logic [AW-1:0]   rd_pa;
    logic            rd_valid;
    ptr_chk_e        chk;
    logic [AW-1:0]   ea;
    mout_t           mo_d, mo_q;

    hpor_val_stage #(
        .THREADS(THREADS), .NREG(NREG), .NPTR(NPTR), .AW(AW)
    ) u_val (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_all(flush_all),
        .inv_req  (inv_thr_req),
        .inv_tid  (inv_thr_id),
        .val_req  (val_req),
        .val_tid  (val_tid),
        .val_preg (val_preg),
        .val_vaddr(val_vaddr),
        .tlb_req  (tlb_req),
        .tlb_va   (tlb_va),
        .tlb_pa   (tlb_pa),
        .tlb_fault(tlb_fault),
        .wr_en    (wr_en),
        .wr_tid   (wr_tid),
        .wr_pidx  (wr_pidx),
        .wr_ok    (wr_ok),
        .wr_pa    (wr_pa),
        .val_done (val_done),
        .val_fault(val_fault)
    );

    hpor_ptr_file #(
        .THREADS(THREADS), .NPTR(NPTR), .AW(AW)
    ) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_all(flush_all),
        .inv_req  (inv_thr_req),
        .inv_tid  (inv_thr_id),
        .wr_en    (wr_en),
        .wr_tid   (wr_tid),
        .wr_pidx  (wr_pidx),
        .wr_ok    (wr_ok),
        .wr_pa    (wr_pa),
        .rd_tid   (op_tid),
        .rd_pidx  (rd_pidx),
        .rd_pa    (rd_pa),
        .rd_valid (rd_valid)
    );

    hpor_ea_form #(
        .NREG(NREG), .NPTR(NPTR), .AW(AW), .DW(DW), .OFFW(OFFW)
    ) u_ea (
        .op_preg  (op_preg),
        .ptr_valid(rd_valid),
        .ptr_pa   (rd_pa),
        .use_imm  (op_use_imm),
        .imm      (op_imm),
        .roff     (op_roff),
        .chk      (chk),
        .pidx     (rd_pidx),
        .ea       (ea)
    );

    always_comb begin
        mo_d = '0;
        if (op_req) begin
            if (chk == CHK_OK) begin
                mo_d.req   = 1'b1;
                mo_d.we    = (acc_e'(op_store) == ACC_STORE);
                mo_d.addr  = ea;
                mo_d.wdata = mo_d.we ? op_wdata : '0;
            end else begin
                mo_d.err   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mo_q <= '0;
        end else begin
            mo_q <= mo_d;
        end
    end

    assign mem_req   = mo_q.req;
    assign mem_we    = mo_q.we;
    assign mem_addr  = mo_q.addr;
    assign mem_wdata = mo_q.wdata;
    assign op_err    = mo_q.err;

endmodule

// File: rtl/hpor_lsu_chk.sv
module hpor_lsu_chk #(
    parameter int NREG  = 16,
    parameter int NPTR  = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int RIDW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush_all,
    input logic            val_req,
    input logic [RIDW-1:0] val_preg,
    input logic            tlb_req,
    input logic            val_done,
    input logic            val_fault,
    input logic            op_req,
    input logic [RIDW-1:0] op_preg,
    input logic            mem_req,
    input logic            mem_we,
    input logic [AW-1:0]   mem_addr,
    input logic [DW-1:0]   mem_wdata,
    input logic            op_err
);

    localparam int PTR_BASE = NREG - NPTR;

    logic flush_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
        end else begin
            flush_q <= flush_all;
        end
    end

    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |=> (mem_req != op_err));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_req |=> (!mem_req && !op_err));

    a_r3_val_response: assert property (@(posedge clk) disable iff (!rst_n)
        val_req |=> val_done);

    a_r3_val_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !val_req |=> (!val_done && !val_fault));

    a_r5_no_lookup_low: assert property (@(posedge clk) disable iff (!rst_n)
        (val_req && (val_preg < RIDW'(PTR_BASE))) |-> !tlb_req);

    a_r5_low_val_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (val_req && (val_preg < RIDW'(PTR_BASE))) |=> val_fault);

    a_r6_low_reg_err: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && (op_preg < RIDW'(PTR_BASE))) |=> (op_err && !mem_req));

    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r10_load_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_wdata == '0));

    a_r11_flush_then_err: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && flush_q) |=> op_err);

endmodule

bind hpor_lsu hpor_lsu_chk #(
    .NREG(NREG), .NPTR(NPTR), .AW(AW), .DW(DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_all(flush_all),
    .val_req  (val_req),
    .val_preg (val_preg),
    .tlb_req  (tlb_req),
    .val_done (val_done),
    .val_fault(val_fault),
    .op_req   (op_req),
    .op_preg  (op_preg),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .op_err   (op_err)
);

// File: tb/sim_hpor_lsu.sv
module sim_hpor_lsu;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        flush_all, inv_thr_req, val_req, op_req, op_store, op_use_imm;
    logic [1:0]  inv_thr_id, val_tid, op_tid;
    logic [3:0]  val_preg, op_preg;
    logic [31:0] val_vaddr, op_roff, op_wdata;
    logic [11:0] op_imm;
    logic        tlb_req, tlb_fault, val_done, val_fault;
    logic [31:0] tlb_va, tlb_pa, mem_addr, mem_wdata;
    logic        mem_req, mem_we, op_err;

    hpor_lsu u0 (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
        .inv_thr_req(inv_thr_req), .inv_thr_id(inv_thr_id),
        .val_req(val_req), .val_tid(val_tid), .val_preg(val_preg), .val_vaddr(val_vaddr),
        .tlb_req(tlb_req), .tlb_va(tlb_va), .tlb_pa(tlb_pa), .tlb_fault(tlb_fault),
        .val_done(val_done), .val_fault(val_fault),
        .op_req(op_req), .op_tid(op_tid), .op_preg(op_preg), .op_store(op_store),
        .op_use_imm(op_use_imm), .op_imm(op_imm), .op_roff(op_roff), .op_wdata(op_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .op_err(op_err)
    );

    // Translation environment: fixed remap of the page bits, top nibble F faults
    function automatic logic [31:0] xl(input logic [31:0] va);
        return {va[31:12] ^ 20'h5A3C1, va[11:0]};
    endfunction

    assign tlb_pa    = xl(tlb_va);
    assign tlb_fault = (tlb_va[31:28] == 4'hF);

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string phase = "init";

    logic [31:0] m_pa [4][4];
    bit          m_v  [4][4];

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s): actual %h expected %h", r, phase, act, exp);
        end
    endtask

    task automatic idle_in();
        flush_all = 0; inv_thr_req = 0; inv_thr_id = 0;
        val_req = 0; val_tid = 0; val_preg = 0; val_vaddr = 0;
        op_req = 0; op_tid = 0; op_preg = 0; op_store = 0; op_use_imm = 0;
        op_imm = 0; op_roff = 0; op_wdata = 0;
    endtask

    // One clock: predict from the model, check lookup port, clock, update model, check outputs
    task automatic run_cycle();
        logic        e_req, e_err, e_we, e_done, e_fault, e_treq;
        logic [31:0] e_addr, e_wd;
        logic [11:0] off;
        string       tg, vtg;
        e_req = 0; e_err = 0; e_we = 0; e_addr = 0; e_wd = 0; tg = "R2";
        if (op_req) begin
            if (op_preg < 12) begin
                e_err = 1; tg = "R6";
            end else if (!m_v[op_tid][int'(op_preg) - 12]) begin
                e_err = 1; tg = "R7";
            end else begin
                off    = op_use_imm ? op_imm : op_roff[11:0];
                e_req  = 1;
                e_we   = op_store;
                e_addr = (m_pa[op_tid][int'(op_preg) - 12] | {20'h0, off}) & 32'hFFFF_FFFC;
                e_wd   = op_store ? op_wdata : 32'h0;
                tg     = op_use_imm ? "R8" : "R9";
            end
        end
        e_treq  = val_req && (val_preg >= 12);
        e_done  = val_req;
        e_fault = val_req && ((val_preg < 12) || flush_all ||
                  (inv_thr_req && inv_thr_id == val_tid) || (val_vaddr[31:28] == 4'hF));
        if (val_preg < 12)                                 vtg = "R5";
        else if (flush_all)                                vtg = "R11";
        else if (inv_thr_req && inv_thr_id == val_tid)     vtg = "R12";
        else if (val_vaddr[31:28] == 4'hF)                 vtg = "R4";
        else                                               vtg = "R3";
        #1;
        chk(vtg, 32'(tlb_req), 32'(e_treq));
        if (e_treq) chk("R3", tlb_va, val_vaddr);
        @(posedge clk);
        if (flush_all) begin
            for (int t = 0; t < 4; t++) for (int p = 0; p < 4; p++) m_v[t][p] = 0;
        end else begin
            if (val_req && val_preg >= 12 && !(inv_thr_req && inv_thr_id == val_tid)) begin
                if (val_vaddr[31:28] == 4'hF) m_v[val_tid][int'(val_preg) - 12] = 0;
                else begin
                    m_v[val_tid][int'(val_preg) - 12]  = 1;
                    m_pa[val_tid][int'(val_preg) - 12] = xl(val_vaddr);
                end
            end
            if (inv_thr_req) for (int p = 0; p < 4; p++) m_v[inv_thr_id][p] = 0;
        end
        @(negedge clk);
        chk(tg, 32'(mem_req), 32'(e_req));
        chk(tg, 32'(op_err), 32'(e_err));
        if (e_req) begin
            chk(tg, mem_addr, e_addr);
            chk("R10", 32'(mem_we), 32'(e_we));
            chk("R10", mem_wdata, e_wd);
        end
        chk(vtg, 32'(val_done), 32'(e_done));
        chk(vtg, 32'(val_fault), 32'(e_fault));
    endtask

    task automatic do_val(input logic [1:0] t, input logic [3:0] p, input logic [31:0] va);
        idle_in();
        val_req = 1; val_tid = t; val_preg = p; val_vaddr = va;
        run_cycle();
        idle_in();
    endtask

    task automatic do_op(input logic [1:0] t, input logic [3:0] p, input logic st,
                         input logic ui, input logic [11:0] off, input logic [31:0] wd);
        idle_in();
        op_req = 1; op_tid = t; op_preg = p; op_store = st; op_use_imm = ui;
        // the unused offset source carries junk so that only the selected one matters (R9)
        op_imm  = ui ? off : 12'hFFF;
        op_roff = ui ? 32'hFFFF_FFFF : {20'hDEAD5, off};
        op_wdata = wd;
        run_cycle();
        idle_in();
    endtask

    // Every thread and every register number; slot contents show which survived (R13)
    task automatic sweep(input logic st, input logic [11:0] off);
        for (int t = 0; t < 4; t++)
            for (int p = 0; p < 16; p++)
                do_op(2'(t), 4'(p), st, 1'((t + p) % 2), off,
                      32'h1357_0000 ^ 32'(t * 4099 + p * 77));
    endtask

    function automatic logic [31:0] va_of(input int t, input int p, input int k);
        return {4'(2 + t), 4'(p), 12'(k * 911), 12'((t * 273) ^ (p * 195))};
    endfunction

    task automatic fill_all(input int k);
        for (int t = 0; t < 4; t++)
            for (int p = 12; p < 16; p++)
                do_val(2'(t), 4'(p), va_of(t, p, k));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 4; t++) for (int p = 0; p < 4; p++) begin
            m_v[t][p] = 0; m_pa[t][p] = 0;
        end
        idle_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        phase = "reset";
        // R1: outputs quiet during and right after reset
        chk("R1", 32'(mem_req), 0); chk("R1", 32'(op_err), 0);
        chk("R1", 32'(val_done), 0); chk("R1", 32'(val_fault), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", 32'(mem_req), 0); chk("R1", 32'(op_err), 0);

        phase = "R1 all slots invalid";
        sweep(0, 12'h000);

        phase = "R3 fill";
        fill_all(1);

        phase = "R8 R9 R10 offsets";
        for (int k = 0; k < 8; k++)
            sweep(1'(k), (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : 12'(k * 745));

        phase = "R4 fault";
        do_val(1, 13, 32'hF000_1234);
        do_op(1, 13, 0, 1, 12'h010, 0);
        do_val(3, 12, 32'hF123_4000);
        sweep(0, 12'h3A5);
        do_val(1, 13, va_of(1, 13, 5));
        do_val(3, 12, va_of(3, 12, 5));

        phase = "R5 low register validate";
        do_val(2, 7, 32'h2222_2000);
        do_val(2, 11, 32'hF000_0000);
        sweep(1, 12'h0F0);

        phase = "R12 thread invalidate";
        idle_in();
        inv_thr_req = 1; inv_thr_id = 2;
        val_req = 1; val_tid = 0; val_preg = 14; val_vaddr = va_of(0, 14, 9);
        run_cycle();
        idle_in();
        inv_thr_req = 1; inv_thr_id = 3;
        val_req = 1; val_tid = 3; val_preg = 15; val_vaddr = va_of(3, 15, 9);
        run_cycle();
        idle_in();
        sweep(0, 12'h555);

        phase = "R14 same-cycle collisions";
        do_val(1, 13, va_of(1, 13, 2));
        idle_in();
        op_req = 1; op_tid = 1; op_preg = 13; op_use_imm = 1; op_imm = 12'h00C;
        val_req = 1; val_tid = 1; val_preg = 13; val_vaddr = va_of(1, 13, 3);
        run_cycle();
        do_op(1, 13, 0, 1, 12'h00C, 0);
        idle_in();
        op_req = 1; op_tid = 0; op_preg = 12; op_store = 1; op_use_imm = 0;
        op_roff = 32'h0000_0AA8; op_wdata = 32'hCAFE_F00D;
        flush_all = 1;
        run_cycle();
        idle_in();
        sweep(0, 12'h001);

        phase = "R11 flush with validate";
        fill_all(4);
        idle_in();
        flush_all = 1;
        val_req = 1; val_tid = 0; val_preg = 12; val_vaddr = va_of(0, 12, 6);
        run_cycle();
        idle_in();
        sweep(1, 12'h2C4);

        phase = "R13 refill";
        fill_all(7);
        sweep(1, 12'hABC);
        sweep(0, 12'h7FF);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule